// File: doc/BRIEF.md
# Software Interrupt Stacking Sequencer

This block carries out the software-interrupt instruction of an 8-bit processor core once decode has recognised the inherent-mode opcode 0x83. On a start strobe it takes a snapshot of the register file, steps the program counter past the opcode, and saves the return context on a descending stack in memory, one byte per bus cycle. It then masks further interrupts and loads a new program counter from a two-byte vector held in memory.

The sequence always lasts eleven bus cycles after the start edge. There are five stack writes, two vector reads, one idle bus cycle and three program reads at the new program counter. A one-clock done strobe marks the last of these cycles. The memory port is byte-wide and uses a combinational read: read data must be valid in the same cycle that `mem_re` is high. The updated PC, SP and CCR are available on the register outputs once the block returns to idle.

States, in order: `ST_IDLE`, `ST_PUSH_PCL`, `ST_PUSH_PCH`, `ST_PUSH_X`, `ST_PUSH_A`, `ST_PUSH_CCR`, `ST_VEC_HI`, `ST_VEC_LO`, `ST_GAP`, `ST_PROG0`, `ST_PROG1`, `ST_PROG2`. The transitions are:
- `ST_IDLE` moves to `ST_PUSH_PCL` when `start` is high.
- Each busy state moves unconditionally to the next state in the list.
- `ST_PROG2` returns to `ST_IDLE`.
- A synchronous reset sends any state to `ST_IDLE`.

Top module: `swi_seq`

## Requirements
- R1: A high `start` at a clock edge while idle captures PC+1 (wrapping modulo 2^16), SP, A, X and CCR. Input changes after that edge have no effect on the sequence.
- R2: In cycles 1 to 5 after the start edge, `mem_we` is high and the block writes PC low, PC high, X, A and CCR, in that order. Each write goes to the current SP, and SP then decrements by one, modulo 2^16.
- R3: In cycle 6, `mem_re` is high at address VEC_ADDR, and `mem_rdata` loads the PC high byte. In cycle 7, `mem_re` is high at VEC_ADDR+1, and `mem_rdata` loads the PC low byte.
- R4: In cycle 8, neither `mem_we` nor `mem_re` is asserted.
- R5: In cycles 9, 10 and 11, `mem_re` is high at the new PC, new PC+1 and new PC+2.
- R6: The pushed CCR byte is the captured value. After the push, CCR bit I_BIT (bit 3 by default) is set to 1, and every other CCR bit is unchanged.
- R7: `busy` is high in cycles 1 to 11. `done` is high in cycle 11 only. The block is idle from cycle 12.
- R8: A `start` while busy is ignored. The running sequence keeps its timing and its data.
- R9: A synchronous reset returns the block to idle with `mem_we`, `mem_re`, `done` and `busy` low, and with `pc_out`, `sp_out` and `ccr_out` zero. This holds even in the middle of a sequence.
- R10: `mem_we` and `mem_re` are never high together, and neither is high while idle.
- R11: At the end, `pc_out` holds the vector bytes {high, low} and `sp_out` is the captured SP minus 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the sequence (sampled when idle) |
| pc_in | input | 16 | Program counter at the opcode |
| sp_in | input | 16 | Stack pointer |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | Index register low byte |
| ccr_in | input | 8 | Condition code register |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as mem_re |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| pc_out | output | 16 | Program counter register |
| sp_out | output | 16 | Stack pointer register |
| ccr_out | output | 8 | Condition code register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock strobe in the final cycle |

## Verification
A wrong state shows on the bus in the same cycle, because address, data and both enables decode directly from the state register. A skipped or repeated state moves every later access by one cycle and puts `done` off cycle 11. A wrong context register shows as a bad pushed byte within five cycles. An error in the SP or PC update shows on `sp_out` or `pc_out` once the block is idle again. The cycle-by-cycle bus check after each start, followed by the register check in cycle 12, catches each of these cases within twelve cycles.

// File: rtl/swi_pkg.sv
package swi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_PUSH_PCL = 4'd1,
        ST_PUSH_PCH = 4'd2,
        ST_PUSH_X   = 4'd3,
        ST_PUSH_A   = 4'd4,
        ST_PUSH_CCR = 4'd5,
        ST_VEC_HI   = 4'd6,
        ST_VEC_LO   = 4'd7,
        ST_GAP      = 4'd8,
        ST_PROG0    = 4'd9,
        ST_PROG1    = 4'd10,
        ST_PROG2    = 4'd11
    } swi_state_e;

    localparam logic [7:0] SWI_OPCODE = 8'h83;

    function automatic logic is_push(input swi_state_e s);
        return (s == ST_PUSH_PCL) || (s == ST_PUSH_PCH) || (s == ST_PUSH_X) ||
               (s == ST_PUSH_A)   || (s == ST_PUSH_CCR);
    endfunction

endpackage

// File: rtl/swi_ctrl.sv
module swi_ctrl
    import swi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output swi_state_e state
);

    swi_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:     state_d = start ? ST_PUSH_PCL : ST_IDLE;
            ST_PUSH_PCL: state_d = ST_PUSH_PCH;
            ST_PUSH_PCH: state_d = ST_PUSH_X;
            ST_PUSH_X:   state_d = ST_PUSH_A;
            ST_PUSH_A:   state_d = ST_PUSH_CCR;
            ST_PUSH_CCR: state_d = ST_VEC_HI;
            ST_VEC_HI:   state_d = ST_VEC_LO;
            ST_VEC_LO:   state_d = ST_GAP;
            ST_GAP:      state_d = ST_PROG0;
            ST_PROG0:    state_d = ST_PROG1;
            ST_PROG1:    state_d = ST_PROG2;
            ST_PROG2:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // R8: a start seen while busy never sends the sequence back to the first push
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_PROG2) |=> (state != ST_IDLE && state != ST_PUSH_PCL));

endmodule

// File: rtl/swi_ctx.sv
module swi_ctx
    import swi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int I_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  swi_state_e        state,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] ccr_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] sp_q,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] ccr_q
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic capture;
    assign capture = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            sp_q  <= '0;
            a_q   <= '0;
            x_q   <= '0;
            ccr_q <= '0;
        end else if (capture) begin
            pc_q  <= pc_in + ADDR_W'(1);
            sp_q  <= sp_in;
            a_q   <= a_in;
            x_q   <= x_in;
            ccr_q <= ccr_in;
        end else begin
            if (is_push(state)) sp_q <= sp_q - ADDR_W'(1);
            if (state == ST_PUSH_CCR) ccr_q[I_BIT] <= 1'b1;
            if (state == ST_VEC_HI) pc_q[ADDR_W-1:DATA_W] <= rdata[HI_W-1:0];
            if (state == ST_VEC_LO) pc_q[DATA_W-1:0] <= rdata;
        end
    end

    // R6: once the CCR byte has been pushed, the mask bit is set
    a_r6_mask_set: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSH_CCR) |=> ccr_q[I_BIT]);

    // R1: the saved A and X never move while a sequence runs
    a_r1_ctx_hold: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(a_q) && $stable(x_q)));

endmodule

// File: rtl/swi_bus.sv
module swi_bus
    import swi_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [15:0]     VEC_ADDR = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  swi_state_e        state,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [DATA_W-1:0] a_q,
    input  logic [DATA_W-1:0] x_q,
    input  logic [DATA_W-1:0] ccr_q,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we,
    output logic              re,
    output logic              done
);

    localparam logic [ADDR_W-1:0] VEC_HI_A = ADDR_W'(VEC_ADDR);
    localparam logic [ADDR_W-1:0] VEC_LO_A = ADDR_W'(VEC_ADDR) + ADDR_W'(1);

    always_comb begin
        addr  = '0;
        wdata = '0;
        we    = 1'b0;
        re    = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PUSH_PCL: begin addr = sp_q; wdata = pc_q[DATA_W-1:0]; we = 1'b1; end
            ST_PUSH_PCH: begin addr = sp_q; wdata = DATA_W'(pc_q[ADDR_W-1:DATA_W]); we = 1'b1; end
            ST_PUSH_X:   begin addr = sp_q; wdata = x_q;   we = 1'b1; end
            ST_PUSH_A:   begin addr = sp_q; wdata = a_q;   we = 1'b1; end
            ST_PUSH_CCR: begin addr = sp_q; wdata = ccr_q; we = 1'b1; end
            ST_VEC_HI:   begin addr = VEC_HI_A; re = 1'b1; end
            ST_VEC_LO:   begin addr = VEC_LO_A; re = 1'b1; end
            ST_GAP: ;
            ST_PROG0:    begin addr = pc_q;               re = 1'b1; end
            ST_PROG1:    begin addr = pc_q + ADDR_W'(1);  re = 1'b1; end
            ST_PROG2:    begin addr = pc_q + ADDR_W'(2);  re = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    // R7: done lasts exactly one clock
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: the cycle after the low vector read is quiet on the bus
    a_r4_gap_quiet: assert property (@(posedge clk) disable iff (rst)
        (re && addr == VEC_LO_A && state == ST_VEC_LO) |=> (!we && !re));

endmodule

// File: rtl/swi_seq.sv
module swi_seq
    import swi_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          I_BIT    = 3,
    parameter logic [15:0] VEC_ADDR = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] ccr_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [DATA_W-1:0] ccr_out,
    output logic              busy,
    output logic              done
);

    swi_state_e        state;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] x_q;

    swi_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .state (state)
    );

    swi_ctx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .I_BIT(I_BIT)) u_ctx (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .start  (start),
        .pc_in  (pc_in),
        .sp_in  (sp_in),
        .a_in   (a_in),
        .x_in   (x_in),
        .ccr_in (ccr_in),
        .rdata  (mem_rdata),
        .pc_q   (pc_out),
        .sp_q   (sp_out),
        .a_q    (a_q),
        .x_q    (x_q),
        .ccr_q  (ccr_out)
    );

    swi_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_ADDR(VEC_ADDR)) u_bus (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .pc_q  (pc_out),
        .sp_q  (sp_out),
        .a_q   (a_q),
        .x_q   (x_q),
        .ccr_q (ccr_out),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .we    (mem_we),
        .re    (mem_re),
        .done  (done)
    );

    assign busy = (state != ST_IDLE);

    // R2: every stack write lands at the current SP
    a_r2_write_at_sp: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == sp_out));

    // R2: SP drops by one after each stack write
    a_r2_sp_step: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_out == $past(sp_out) - ADDR_W'(1)));

    // R10: the two enables never overlap
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R10: the bus stays quiet while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re && !done));

    // R7: the block stays busy until the done cycle
    a_r7_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: tb/swi_seq_bench.sv
module swi_seq_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] VEC        = 16'hFFFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic [7:0]  a_in = '0, x_in = '0, ccr_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, ccr_out;
    logic        mem_we, mem_re, busy, done;
    logic [7:0]  vec_hi = 8'h00, vec_lo = 8'h00;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = (mem_addr == VEC) ? vec_hi :
                       (mem_addr == VEC + 16'd1) ? vec_lo : 8'h5A;

    swi_seq #(.VEC_ADDR(VEC)) u_swi_seq (
        .clk(clk), .rst(rst), .start(start),
        .pc_in(pc_in), .sp_in(sp_in), .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .pc_out(pc_out), .sp_out(sp_out),
        .ccr_out(ccr_out), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // R9: reset state at the ports
    task automatic t_reset_state();
        @(negedge clk);
        check(!busy && !done, "R9 busy/done", {busy, done}, 0);
        check(!mem_we && !mem_re, "R9 enables", {mem_we, mem_re}, 0);
        check(pc_out == 0 && sp_out == 0 && ccr_out == 0, "R9 regs", {pc_out, sp_out}, 0);
    endtask

    // Run a sequence and check every cycle; disturb changes inputs and pulses start while busy (R1, R8)
    task automatic run_seq(input logic [15:0] pc0, input logic [15:0] sp0, input logic [7:0] a0,
                           input logic [7:0] x0, input logic [7:0] c0, input logic [7:0] vh,
                           input logic [7:0] vl, input bit disturb);
        logic [15:0] pc1, nv, exp_addr;
        logic [7:0]  exp_data;
        bit          exp_we, exp_re;
        pc1 = pc0 + 16'd1;
        nv  = {vh, vl};
        vec_hi = vh; vec_lo = vl;
        @(negedge clk);
        pc_in = pc0; sp_in = sp0; a_in = a0; x_in = x0; ccr_in = c0;
        start = 1'b1;
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start = 1'b0;
                if (disturb) begin
                    pc_in = ~pc0; sp_in = ~sp0; a_in = ~a0; x_in = ~x0; ccr_in = ~c0;
                end
            end
            if (disturb && k == 4) start = 1'b1;
            if (disturb && k == 6) start = 1'b0;
            exp_we = 0; exp_re = 0; exp_addr = '0; exp_data = '0;
            case (k)
                1: begin exp_we = 1; exp_addr = sp0;         exp_data = pc1[7:0];  end
                2: begin exp_we = 1; exp_addr = sp0 - 16'd1; exp_data = pc1[15:8]; end
                3: begin exp_we = 1; exp_addr = sp0 - 16'd2; exp_data = x0;        end
                4: begin exp_we = 1; exp_addr = sp0 - 16'd3; exp_data = a0;        end
                5: begin exp_we = 1; exp_addr = sp0 - 16'd4; exp_data = c0;        end
                6: begin exp_re = 1; exp_addr = VEC;         end
                7: begin exp_re = 1; exp_addr = VEC + 16'd1; end
                9, 10, 11: begin exp_re = 1; exp_addr = nv + 16'(k - 9); end
                default: ;
            endcase
            check(mem_we == exp_we && mem_re == exp_re,
                  (k <= 5) ? "R2 write enable" : (k == 8) ? "R4 quiet gap" : (k <= 7) ? "R3 vector read" : "R5 program read",
                  {mem_we, mem_re}, {exp_we, exp_re});
            if (exp_we || exp_re)
                check(mem_addr == exp_addr, (k <= 5) ? "R2 stack addr" : (k <= 7) ? "R3 vector addr" : "R5 program addr",
                      mem_addr, exp_addr);
            if (exp_we)
                check(mem_wdata == exp_data, (k == 5) ? "R6 pushed CCR" : "R2 pushed byte", mem_wdata, exp_data);
            check(busy && (done == (k == 11)), "R7 busy/done", {busy, done}, {1'b1, k == 11});
        end
        @(negedge clk);
        check(!busy && !done, "R7 idle after", {busy, done}, 0);
        check(pc_out == nv, "R11 new PC", pc_out, nv);
        check(sp_out == sp0 - 16'd5, "R11 final SP", sp_out, sp0 - 16'd5);
        check(ccr_out == (c0 | 8'h08), "R6 mask set", ccr_out, c0 | 8'h08);
    endtask

    task automatic t_basic();      run_seq(16'h1234, 16'h00FF, 8'hA1, 8'hB2, 8'hE5, 8'h80, 8'h40, 0); endtask
    task automatic t_wrap();       run_seq(16'hFFFF, 16'h0002, 8'h3C, 8'hC3, 8'h08, 8'hFF, 8'hFE, 0); endtask  // R1 PC wrap, R2 SP wrap
    task automatic t_disturb();    run_seq(16'h4000, 16'h8000, 8'h11, 8'h22, 8'h00, 8'h12, 8'h34, 1); endtask  // R1, R8
    task automatic t_back2back();  run_seq(16'h0100, 16'h7FFB, 8'h55, 8'hAA, 8'hF7, 8'h00, 8'h01, 0); endtask

    // R9: reset in the middle of a sequence
    task automatic t_mid_reset();
        @(negedge clk);
        pc_in = 16'h2222; sp_in = 16'h3333; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !mem_we && !mem_re && !done, "R9 mid reset idle", {busy, mem_we, mem_re, done}, 0);
        check(sp_out == 0 && pc_out == 0 && ccr_out == 0, "R9 mid reset regs", {pc_out, sp_out}, 0);
        @(negedge clk);
        check(!busy, "R9 stays idle", busy, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual %h expected %h", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        rst = 1'b0;
        t_basic();
        t_wrap();
        t_disturb();
        t_back2back();
        t_mid_reset();
        t_basic();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule